// File: doc/BRIEF.md
# RTC Interrupt Output Merger

This block sits beside the timekeeping logic of a real-time clock and turns three event sources into one shared, active-low interrupt line. The sources are the periodic time update, the fixed-cycle timer and the alarm. Each source has an enable bit in a host-accessible control byte. That byte also carries a halt bit and a counter-reset bit, which the block passes on to the timekeeping logic.

Every event pulse sets a sticky flag for its source, whether or not the source is enabled. The host can therefore poll the flags with all interrupts disabled. An event on an enabled source raises a request. Update and timer requests drop by themselves after a window of 256 ticks of the 32.768 kHz clock enable, which is 1/128 s. An alarm request stays up until the host clears the alarm flag. Writing 0 to an enable bit withdraws that source's request at once.

The line is modelled for an open-drain pad. The data value is always low, and the output enable is high while any request is active.

Top module: `rtc_irq_merge`

## Requirements
- R1: Control byte layout: bit 5 enables the update source, bit 4 enables the timer source, bit 3 enables the alarm source, bit 1 is halt and bit 0 is counter reset. These bits read back as written, and bits 1 and 0 also appear on `halt_o` and `cnt_rst_o`.
- R2: Bits 7, 6 and 2 of the control byte ignore writes and always read 0.
- R3: An event pulse sets its source's flag in the cycle after the pulse, whatever the enable bit is. In the flag byte, bit 0 is update, bit 1 is timer and bit 2 is alarm.
- R4: A flag write clears each flag whose written bit is 0 and leaves alone each flag whose written bit is 1. When a clear and an event for the same flag arrive in the same cycle, the event wins.
- R5: An event on an enabled source sets `irq_oe` from the next cycle. An event on a disabled source leaves `irq_oe` at 0.
- R6: An update or timer request is released on the 256th cycle with `tick_en` high after its event. A new event on the same source restarts the count.
- R7: An alarm request has no time limit. It stays active until the alarm flag is cleared, and it is gone in the cycle after the clearing write.
- R8: Writing 0 to a source's enable bit withdraws that source's request from the next cycle. This takes priority over an event for that source in the same cycle; the flag is still set.
- R9: `irq_oe` is high while at least one source's request is active, and `irq_n_data` is always 0.
- R10: After synchronous reset, the control byte reads 0x00, all flags read 0 and `irq_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | 32.768 kHz clock-enable pulse |
| evt_upd | input | 1 | Time-update event pulse |
| evt_tmr | input | 1 | Fixed-cycle timer event pulse |
| evt_alm | input | 1 | Alarm match event pulse |
| ctrl_we | input | 1 | Control byte write strobe |
| ctrl_wdata | input | 8 | Control byte write value |
| ctrl_rdata | output | 8 | Control byte read value |
| flag_we | input | 1 | Flag write strobe |
| flag_wdata | input | 3 | Flag write value; a 0 bit clears that flag |
| flag_rdata | output | 3 | Flag read value |
| halt_o | output | 1 | Halt bit, passed to the timekeeping logic |
| cnt_rst_o | output | 1 | Counter-reset bit, passed to the timekeeping logic |
| irq_n_data | output | 1 | Interrupt pad data, always 0 |
| irq_oe | output | 1 | Interrupt pad output enable; high means the line is driven low |

## Verification
The bound checker watches these properties on every cycle:
- the reserved control bits stay at zero;
- an event sets its flag;
- an enabled update event raises the line;
- an alarm request survives any cycle that neither clears its flag nor disables it;
- disabling all sources drops the line;
- the pad data never leaves 0.

Only the directed scenarios can show the rest:
- the exact 256-tick release and its restart;
- the event-over-clear priority on a flag;
- the cancel-over-event priority on a request;
- the alarm holding the line after a timed source has timed out.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

    localparam int NUM_SRC = 3;
    localparam int CTRL_W  = 8;

    // Source indices; they also give the bit positions in the flag byte.
    typedef enum logic [1:0] {
        SRC_UPD = 2'd0,
        SRC_TMR = 2'd1,
        SRC_ALM = 2'd2
    } src_e;

    // How a source's request is withdrawn.
    typedef enum logic {
        REL_TIMED    = 1'b0,
        REL_ON_CLEAR = 1'b1
    } release_e;

    // Control byte, most significant field first.
    typedef struct packed {
        logic [1:0] rsv_hi;
        logic       upd_en;
        logic       tmr_en;
        logic       alm_en;
        logic       rsv_mid;
        logic       halt;
        logic       cnt_rst;
    } ctrl_t;

    // Bits 5, 4, 3, 1 and 0 are writable.
    localparam logic [CTRL_W-1:0] CTRL_WR_MASK = 8'h3B;

    // Position of a source's enable bit in the control byte.
    function automatic int en_bit(input int src);
        case (src)
            0:       return 5;
            1:       return 4;
            default: return 3;
        endcase
    endfunction

    // Release behaviour for each source: only the alarm waits for a flag clear.
    function automatic release_e release_kind(input int src);
        return (src == int'(SRC_ALM)) ? REL_ON_CLEAR : REL_TIMED;
    endfunction

endpackage

// File: rtl/rtc_irq_ctrl_reg.sv
module rtc_irq_ctrl_reg
    import rtc_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [CTRL_W-1:0]   wdata,
    output ctrl_t               q,
    output logic [NUM_SRC-1:0]  en,
    output logic [NUM_SRC-1:0]  cancel
);

    ctrl_t q_r;

    always_ff @(posedge clk) begin
        if (rst)
            q_r <= '0;
        else if (we)
            q_r <= ctrl_t'(wdata & CTRL_WR_MASK);
    end

    assign q = q_r;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_en
        localparam int BIT = en_bit(s);
        assign en[s]     = q_r[BIT];
        assign cancel[s] = we && !wdata[BIT];
    end

endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags
    import rtc_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_SRC-1:0]  evt,
    input  logic                we,
    input  logic [NUM_SRC-1:0]  wdata,
    output logic [NUM_SRC-1:0]  flags
);

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_flag
        logic f_r;
        always_ff @(posedge clk) begin
            if (rst)
                f_r <= 1'b0;
            else if (evt[s])
                f_r <= 1'b1;          // an event beats a same-cycle clear
            else if (we && !wdata[s])
                f_r <= 1'b0;
        end
        assign flags[s] = f_r;
    end

endmodule

// File: rtl/rtc_irq_timed_src.sv
module rtc_irq_timed_src #(
    parameter int TICK_LIMIT = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_en,
    input  logic evt,
    input  logic en,
    input  logic cancel,
    output logic req
);

    localparam int CNT_W = (TICK_LIMIT > 2) ? $clog2(TICK_LIMIT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_LIMIT - 1);

    logic             req_r;
    logic [CNT_W-1:0] cnt_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_r <= 1'b0;
            cnt_r <= '0;
        end else if (cancel) begin
            req_r <= 1'b0;
        end else if (evt && en) begin
            req_r <= 1'b1;
            cnt_r <= '0;              // a new event restarts the window
        end else if (req_r && tick_en) begin
            if (cnt_r == LAST)
                req_r <= 1'b0;
            else
                cnt_r <= cnt_r + 1'b1;
        end
    end

    assign req = req_r;

endmodule

// File: rtl/rtc_irq_held_src.sv
module rtc_irq_held_src (
    input  logic clk,
    input  logic rst,
    input  logic evt,
    input  logic en,
    input  logic cancel,
    input  logic flag_clr,
    output logic req
);

    logic req_r;

    always_ff @(posedge clk) begin
        if (rst)
            req_r <= 1'b0;
        else if (cancel)
            req_r <= 1'b0;
        else if (evt && en)
            req_r <= 1'b1;
        else if (flag_clr && !evt)
            req_r <= 1'b0;
    end

    assign req = req_r;

endmodule

// File: rtl/rtc_irq_merge.sv
module rtc_irq_merge
    import rtc_irq_pkg::*;
#(
    parameter int TICK_LIMIT = 256
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick_en,
    input  logic                evt_upd,
    input  logic                evt_tmr,
    input  logic                evt_alm,
    input  logic                ctrl_we,
    input  logic [CTRL_W-1:0]   ctrl_wdata,
    output logic [CTRL_W-1:0]   ctrl_rdata,
    input  logic                flag_we,
    input  logic [NUM_SRC-1:0]  flag_wdata,
    output logic [NUM_SRC-1:0]  flag_rdata,
    output logic                halt_o,
    output logic                cnt_rst_o,
    output logic                irq_n_data,
    output logic                irq_oe
);

    ctrl_t               ctrl_q;
    logic [NUM_SRC-1:0]  en;
    logic [NUM_SRC-1:0]  cancel;
    logic [NUM_SRC-1:0]  evt;
    logic [NUM_SRC-1:0]  src_req;

    assign evt = {evt_alm, evt_tmr, evt_upd};

    rtc_irq_ctrl_reg u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .we     (ctrl_we),
        .wdata  (ctrl_wdata),
        .q      (ctrl_q),
        .en     (en),
        .cancel (cancel)
    );

    rtc_irq_flags u_flags (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .we     (flag_we),
        .wdata  (flag_wdata),
        .flags  (flag_rdata)
    );

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        if (release_kind(s) == REL_TIMED) begin : g_timed
            rtc_irq_timed_src #(.TICK_LIMIT(TICK_LIMIT)) u_src (
                .clk     (clk),
                .rst     (rst),
                .tick_en (tick_en),
                .evt     (evt[s]),
                .en      (en[s]),
                .cancel  (cancel[s]),
                .req     (src_req[s])
            );
        end else begin : g_held
            rtc_irq_held_src u_src (
                .clk      (clk),
                .rst      (rst),
                .evt      (evt[s]),
                .en       (en[s]),
                .cancel   (cancel[s]),
                .flag_clr (flag_we && !flag_wdata[s]),
                .req      (src_req[s])
            );
        end
    end

    assign ctrl_rdata = ctrl_q;
    assign halt_o     = ctrl_q.halt;
    assign cnt_rst_o  = ctrl_q.cnt_rst;
    assign irq_n_data = 1'b0;
    assign irq_oe     = |src_req;

endmodule

// File: rtl/rtc_irq_merge_chk.sv
module rtc_irq_merge_chk (
    input logic       clk,
    input logic       rst,
    input logic       evt_upd,
    input logic       ctrl_we,
    input logic [7:0] ctrl_wdata,
    input logic [7:0] ctrl_rdata,
    input logic       flag_we,
    input logic [2:0] flag_wdata,
    input logic [2:0] flag_rdata,
    input logic [2:0] src_req,
    input logic       irq_n_data,
    input logic       irq_oe
);

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (ctrl_rdata[7:6] == 2'b00) && !ctrl_rdata[2]);

    a_r3_flag_on_event: assert property (@(posedge clk) disable iff (rst)
        evt_upd |=> flag_rdata[0]);

    a_r5_enabled_raises: assert property (@(posedge clk) disable iff (rst)
        (evt_upd && ctrl_rdata[5] && !ctrl_we) |=> irq_oe);

    a_r7_alarm_hold: assert property (@(posedge clk) disable iff (rst)
        (src_req[2] && !(flag_we && !flag_wdata[2]) && !(ctrl_we && !ctrl_wdata[3]))
        |=> src_req[2]);

    a_r8_cancel_all: assert property (@(posedge clk) disable iff (rst)
        (ctrl_we && (ctrl_wdata[5:3] == 3'b000)) |=> !irq_oe);

    a_r9_data_low: assert property (@(posedge clk) disable iff (rst)
        irq_n_data == 1'b0);

endmodule

bind rtc_irq_merge rtc_irq_merge_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .evt_upd    (evt_upd),
    .ctrl_we    (ctrl_we),
    .ctrl_wdata (ctrl_wdata),
    .ctrl_rdata (ctrl_rdata),
    .flag_we    (flag_we),
    .flag_wdata (flag_wdata),
    .flag_rdata (flag_rdata),
    .src_req    (src_req),
    .irq_n_data (irq_n_data),
    .irq_oe     (irq_oe)
);

// File: tb/rtc_irq_merge_bench.sv
module rtc_irq_merge_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic       evt_upd = 1'b0;
    logic       evt_tmr = 1'b0;
    logic       evt_alm = 1'b0;
    logic       ctrl_we = 1'b0;
    logic [7:0] ctrl_wdata = '0;
    logic [7:0] ctrl_rdata;
    logic       flag_we = 1'b0;
    logic [2:0] flag_wdata = '0;
    logic [2:0] flag_rdata;
    logic       halt_o;
    logic       cnt_rst_o;
    logic       irq_n_data;
    logic       irq_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    rtc_irq_merge u_rtc_irq_merge (
        .clk        (clk),
        .rst        (rst),
        .tick_en    (tick_en),
        .evt_upd    (evt_upd),
        .evt_tmr    (evt_tmr),
        .evt_alm    (evt_alm),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (ctrl_wdata),
        .ctrl_rdata (ctrl_rdata),
        .flag_we    (flag_we),
        .flag_wdata (flag_wdata),
        .flag_rdata (flag_rdata),
        .halt_o     (halt_o),
        .cnt_rst_o  (cnt_rst_o),
        .irq_n_data (irq_n_data),
        .irq_oe     (irq_oe)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, got, exp);
        end
    endtask

    // Inputs change only just after a falling edge; outputs are read there too.
    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        ctrl_we = 1'b1; ctrl_wdata = v;
        cyc();
        ctrl_we = 1'b0;
    endtask

    task automatic wr_flags(input logic [2:0] v);
        flag_we = 1'b1; flag_wdata = v;
        cyc();
        flag_we = 1'b0;
    endtask

    task automatic pulse(input logic u, input logic t, input logic a);
        evt_upd = u; evt_tmr = t; evt_alm = a;
        cyc();
        evt_upd = 1'b0; evt_tmr = 1'b0; evt_alm = 1'b0;
    endtask

    task automatic ticks(input int n);
        tick_en = 1'b1;
        repeat (n) cyc();
        tick_en = 1'b0;
    endtask

    task automatic idle_state();
        wr_ctrl(8'h00);
        wr_flags(3'b000);
    endtask

    task automatic t_reset();
        check("R10", "ctrl after reset", ctrl_rdata, 8'h00);
        check("R10", "flags after reset", flag_rdata, 3'b000);
        check("R10", "oe after reset", irq_oe, 1'b0);
        check("R9", "pad data", irq_n_data, 1'b0);
    endtask

    task automatic t_ctrl_layout();
        wr_ctrl(8'hFF);
        check("R1", "writable bits", ctrl_rdata, 8'h3B);
        check("R1", "halt out", halt_o, 1'b1);
        check("R1", "counter reset out", cnt_rst_o, 1'b1);
        wr_ctrl(8'h22);
        check("R1", "update enable and halt", ctrl_rdata, 8'h22);
        check("R1", "counter reset cleared", cnt_rst_o, 1'b0);
        wr_ctrl(8'hC4);
        check("R2", "reserved bits", ctrl_rdata, 8'h00);
        idle_state();
    endtask

    task automatic t_poll_and_clear();
        idle_state();
        pulse(1'b1, 1'b0, 1'b0);
        check("R3", "update flag while disabled", flag_rdata, 3'b001);
        check("R5", "disabled source keeps line released", irq_oe, 1'b0);
        pulse(1'b0, 1'b1, 1'b1);
        check("R3", "timer and alarm flags", flag_rdata, 3'b111);
        check("R5", "still released", irq_oe, 1'b0);
        wr_flags(3'b110);
        check("R4", "selective clear", flag_rdata, 3'b110);
        flag_we = 1'b1; flag_wdata = 3'b000; evt_upd = 1'b1;
        cyc();
        flag_we = 1'b0; evt_upd = 1'b0;
        check("R4", "event beats clear", flag_rdata, 3'b001);
        idle_state();
    endtask

    task automatic t_timed_release();
        idle_state();
        wr_ctrl(8'h20);
        pulse(1'b1, 1'b0, 1'b0);
        check("R5", "enabled update raises line", irq_oe, 1'b1);
        ticks(255);
        check("R6", "held after 255 ticks", irq_oe, 1'b1);
        ticks(1);
        check("R6", "released on tick 256", irq_oe, 1'b0);
        wr_ctrl(8'h10);
        pulse(1'b0, 1'b1, 1'b0);
        check("R5", "enabled timer raises line", irq_oe, 1'b1);
        ticks(100);
        pulse(1'b0, 1'b1, 1'b0);
        ticks(255);
        check("R6", "restart keeps line up", irq_oe, 1'b1);
        ticks(1);
        check("R6", "released 256 ticks after restart", irq_oe, 1'b0);
        idle_state();
    endtask

    task automatic t_alarm_hold();
        idle_state();
        wr_ctrl(8'h08);
        pulse(1'b0, 1'b0, 1'b1);
        check("R5", "alarm raises line", irq_oe, 1'b1);
        ticks(600);
        check("R7", "alarm has no timeout", irq_oe, 1'b1);
        wr_flags(3'b111);
        check("R7", "writing ones keeps alarm", irq_oe, 1'b1);
        wr_flags(3'b011);
        check("R7", "alarm flag cleared", flag_rdata[2], 1'b0);
        check("R7", "alarm line released", irq_oe, 1'b0);
        idle_state();
    endtask

    task automatic t_cancel();
        idle_state();
        wr_ctrl(8'h38);
        pulse(1'b1, 1'b0, 1'b0);
        check("R5", "update raises line", irq_oe, 1'b1);
        wr_ctrl(8'h18);
        check("R8", "disabling update cancels", irq_oe, 1'b0);
        ctrl_we = 1'b1; ctrl_wdata = 8'h00; evt_alm = 1'b1;
        cyc();
        ctrl_we = 1'b0; evt_alm = 1'b0;
        check("R8", "cancel beats same-cycle alarm", irq_oe, 1'b0);
        check("R8", "alarm flag still set", flag_rdata[2], 1'b1);
        idle_state();
    endtask

    task automatic t_merge();
        idle_state();
        wr_ctrl(8'h28);
        pulse(1'b1, 1'b0, 1'b1);
        check("R9", "two sources active", irq_oe, 1'b1);
        ticks(256);
        check("R9", "alarm keeps line after update timeout", irq_oe, 1'b1);
        wr_flags(3'b000);
        check("R9", "no source active", irq_oe, 1'b0);
        check("R9", "pad data stays low", irq_n_data, 1'b0);
        idle_state();
    endtask

    initial begin
        repeat (3) cyc();
        rst = 1'b0;
        cyc();
        t_reset();
        t_ctrl_layout();
        t_poll_and_clear();
        t_timed_release();
        t_alarm_hold();
        t_cancel();
        t_merge();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule